// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point operands: 1 sign bit, an 8-bit exponent biased by 127, and a 23-bit fraction. It takes one operation at a time through a valid/ready handshake. It runs the operation through a fixed sequence of register stages and holds the packed result until the consumer takes it. Normal operands carry a hidden leading 1. Subnormal operands carry a hidden 0 and use the exponent of the smallest normal. Infinities and NaN values are resolved before any arithmetic starts.

The sequencer has seven states. IDLE raises `in_ready`. The transition IDLE→UNPACK fires when `in_valid` is high, and the operands and controls are captured on that edge. UNPACK decodes both operands. It takes UNPACK→DONE when an operand is NaN or infinite and writes the special result at once. Otherwise it takes UNPACK→ALIGN. ALIGN orders the operands by magnitude and shifts the smaller significand right, keeping three extra bits. ALIGN→ADD always. ADD forms the sum or difference. ADD→NORM always. NORM shifts left to bring the leading 1 to the top, or right by one on a carry, and never takes the exponent below the subnormal floor. NORM→ROUND always. ROUND applies the selected rounding mode, resolves overflow, flushes the result if asked, and packs it. ROUND→DONE always. DONE raises `out_valid`. It takes DONE→IDLE when `out_ready` is high. An arithmetic operation spends five cycles between acceptance and DONE. A special-value operation spends one.

Rounding-mode encoding on `in_rmode`:
- 00: nearest, ties to even
- 01: toward zero
- 10: toward +infinity
- 11: toward −infinity

`in_sub`=1 computes a−b. The canonical NaN output is 0x7FC00000.

Top module: `fp32_addsub`

## Requirements
- R1: `in_ready` is high only while idle and falls after an accepted request. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sum` hold steady. Reset leaves `in_ready`=1 and `out_valid`=0.
- R2: Sums of normal operands are exact when representable (1.5+2.25 = 0x40700000).
- R3: The result sign follows the larger-magnitude operand after `in_sub` flips the sign of b (1.0−3.0 = 0xC0000000).
- R4: In mode 00, a result exactly halfway between two candidates goes to the candidate whose fraction LSB is 0.
- R5: Modes 01, 10 and 11 round inexact results toward zero, upward and downward respectively, using the guard, round and sticky bits.
- R6: When the exponent gap exceeds the significand width, the smaller operand contributes only to sticky: 0x60AD78EC+1.0 gives 0x60AD78EC in mode 00 and 0x60AD78ED in mode 10.
- R7: A carry out of the significand sum, or out of rounding, shifts right by one and increments the exponent (0x3FFFFFFF+0x33800000 = 0x40000000).
- R8: With `in_ftz`=0, subnormal operands and results are handled with gradual underflow (0x00800001−0x00800000 = 0x00000001).
- R9: With `in_ftz`=1, subnormal operands count as zero of their sign, and a subnormal result becomes zero of its sign.
- R10: An exactly cancelling result is +0 in every mode except 11, where it is −0. Adding two zeros of the same sign gives that zero.
- R11: On overflow, mode 00 gives infinity. Mode 01 gives the largest finite magnitude (exponent 254, fraction all ones). Modes 10 and 11 give infinity when rounding toward it and the largest finite magnitude otherwise.
- R12: Any NaN operand, or the difference of equal-signed infinities, gives 0x7FC00000.
- R13: An infinite operand added to a finite one gives that infinity. Two infinities of the same effective sign give that infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept |
| in_a | input | 32 | Operand a |
| in_b | input | 32 | Operand b |
| in_sub | input | 1 | 1 = a−b, 0 = a+b |
| in_rmode | input | 2 | Rounding mode (encoding above) |
| in_ftz | input | 1 | Flush subnormal operands and results to zero |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 32 | Packed result |

## Verification
The assertions check the output against the operands and controls captured at acceptance. They therefore assume that a request is taken only while `in_ready` is high, and that reset is asserted from time zero. The stimulus raises `in_valid` for exactly one cycle while the block is idle. It returns `out_ready` low after each result is taken. It asserts reset for several cycles before the first request. Every other check in the bench is a directed comparison against hand-derived bit patterns. The patterns were chosen so that the guard, round and sticky bits and the exponent floor and ceiling land on the corner each requirement names.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNPACK,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_ROUND,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic nan;
        logic inf;
    } opclass_t;

endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    input  logic                  ftz,
    output logic                  sign,
    output logic [EXP_W-1:0]      eexp,
    output logic [FRAC_W:0]       sig,
    output opclass_t              cls
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  efld;
    logic [FRAC_W-1:0] ffld;
    logic              e_zero;
    logic              e_ones;
    logic              tiny;

    always_comb begin
        efld    = op[FRAC_W +: EXP_W];
        ffld    = op[FRAC_W-1:0];
        sign    = op[W-1];
        e_zero  = (efld == '0);
        e_ones  = &efld;
        tiny    = e_zero & (|ffld);
        cls.nan = e_ones & (|ffld);
        cls.inf = e_ones & ~(|ffld);
        // subnormals share the exponent of the smallest normal
        eexp    = e_zero ? EXP_W'(1) : efld;
        sig     = {~e_zero, (ftz & tiny) ? {FRAC_W{1'b0}} : ffld};
    end

endmodule

// File: rtl/fp_align.sv
module fp_align #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  sa,
    input  logic [EXP_W-1:0]      ea,
    input  logic [FRAC_W:0]       ma,
    input  logic                  sb,
    input  logic [EXP_W-1:0]      eb,
    input  logic [FRAC_W:0]       mb,
    output logic                  sgn_big,
    output logic                  eff_sub,
    output logic [EXP_W-1:0]      exp_big,
    output logic [FRAC_W+3:0]     big_x,
    output logic [FRAC_W+3:0]     small_x
);
    localparam int SW = FRAC_W + 1;
    localparam int XW = SW + 3;
    localparam logic [EXP_W-1:0] XW_E = EXP_W'(XW);

    logic              a_ge;
    logic [EXP_W-1:0]  e_sm;
    logic [SW-1:0]     m_sm;
    logic [SW-1:0]     m_bg;
    logic [EXP_W-1:0]  diff;
    logic [XW-1:0]     raw;
    logic              lost;

    always_comb begin
        a_ge    = {ea, ma} >= {eb, mb};
        sgn_big = a_ge ? sa : sb;
        exp_big = a_ge ? ea : eb;
        m_bg    = a_ge ? ma : mb;
        e_sm    = a_ge ? eb : ea;
        m_sm    = a_ge ? mb : ma;
        eff_sub = sa ^ sb;
        big_x   = {m_bg, 3'b000};
        diff    = exp_big - e_sm;
        raw     = {m_sm, 3'b000};
        lost    = 1'b0;
        if (diff >= XW_E) begin
            // whole operand falls below the round bit: sticky only
            small_x = {{(XW-1){1'b0}}, |m_sm};
        end else begin
            lost    = |(raw & ~({XW{1'b1}} << diff));
            small_x = (raw >> diff) | {{(XW-1){1'b0}}, lost};
        end
    end

endmodule

// File: rtl/fp_normalize.sv
module fp_normalize #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W+4:0] mag,
    input  logic [EXP_W+1:0]  exp_in,
    output logic [FRAC_W+3:0] norm,
    output logic [EXP_W+1:0]  exp_out
);
    localparam int XW  = FRAC_W + 4;
    localparam int EW2 = EXP_W + 2;

    logic [EW2-1:0] lz;
    logic [EW2-1:0] room;
    logic [EW2-1:0] sh;

    always_comb begin
        lz = EW2'(XW);
        for (int i = 0; i < XW; i++) begin
            if (mag[i]) lz = EW2'(XW - 1 - i);
        end
        // never shift the exponent below the subnormal floor
        room = exp_in - EW2'(1);
        sh   = (lz < room) ? lz : room;
        if (mag[XW]) begin
            norm    = mag[XW:1] | {{(XW-1){1'b0}}, mag[0]};
            exp_out = exp_in + EW2'(1);
        end else begin
            norm    = mag[XW-1:0] << sh;
            exp_out = exp_in - sh;
        end
    end

endmodule

// File: rtl/fp_round.sv
module fp_round
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  sign,
    input  logic [FRAC_W+3:0]     norm,
    input  logic [EXP_W+1:0]      nexp,
    input  rmode_e                rm,
    input  logic                  ftz,
    output logic [EXP_W+FRAC_W:0] res
);
    localparam int XW  = FRAC_W + 4;
    localparam int EW2 = EXP_W + 2;
    localparam logic [EW2-1:0] EXP_TOP = EW2'((1 << EXP_W) - 1);

    logic              lsb, g, r, s, inexact, inc, carry, to_inf, tiny;
    logic [FRAC_W+1:0] sig_r;
    logic [FRAC_W:0]   fsig;
    logic [EW2-1:0]    fexp;
    logic [EXP_W-1:0]  sexp;

    always_comb begin
        lsb     = norm[3];
        g       = norm[2];
        r       = norm[1];
        s       = norm[0];
        inexact = g | r | s;
        unique case (rm)
            RM_NEAR: inc = g & (r | s | lsb);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = inexact & ~sign;
            RM_DOWN: inc = inexact & sign;
            default: inc = 1'b0;
        endcase
        sig_r = {1'b0, norm[XW-1:3]} + {{(FRAC_W+1){1'b0}}, inc};
        carry = sig_r[FRAC_W+1];
        fsig  = carry ? sig_r[FRAC_W+1:1] : sig_r[FRAC_W:0];
        fexp  = nexp + {{(EW2-1){1'b0}}, carry};
        to_inf = (rm == RM_NEAR) | ((rm == RM_UP) & ~sign) | ((rm == RM_DOWN) & sign);
        tiny  = ~fsig[FRAC_W];
        sexp  = tiny ? {EXP_W{1'b0}} : fexp[EXP_W-1:0];
        if (fexp >= EXP_TOP) begin
            res = to_inf ? {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                         : {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else if (ftz & tiny) begin
            res = {sign, {(EXP_W+FRAC_W){1'b0}}};
        end else begin
            res = {sign, sexp, fsig[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [EXP_W+FRAC_W:0] in_a,
    input  logic [EXP_W+FRAC_W:0] in_b,
    input  logic                  in_sub,
    input  logic [1:0]            in_rmode,
    input  logic                  in_ftz,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [EXP_W+FRAC_W:0] out_sum
);
    localparam int W   = 1 + EXP_W + FRAC_W;
    localparam int XW  = FRAC_W + 4;
    localparam int EW2 = EXP_W + 2;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    state_e state, state_nx;

    logic [W-1:0]      a_q, b_q, res_q;
    logic              sub_q, ftz_q;
    rmode_e            rm_q;

    // unpacked operands (held while a_q/b_q are stable)
    logic [W-1:0]      u_op   [2];
    logic              u_sign [2];
    logic [EXP_W-1:0]  u_exp  [2];
    logic [FRAC_W:0]   u_sig  [2];
    opclass_t          u_cls  [2];

    assign u_op[0] = a_q;
    assign u_op[1] = b_q;

    for (genvar k = 0; k < 2; k++) begin : g_unpack
        fp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
            .op   (u_op[k]),
            .ftz  (ftz_q),
            .sign (u_sign[k]),
            .eexp (u_exp[k]),
            .sig  (u_sig[k]),
            .cls  (u_cls[k])
        );
    end

    logic sb_eff;
    logic any_nan, special;
    logic [W-1:0] spec_val;

    always_comb begin
        sb_eff  = u_sign[1] ^ sub_q;
        any_nan = u_cls[0].nan | u_cls[1].nan |
                  (u_cls[0].inf & u_cls[1].inf & (u_sign[0] != sb_eff));
        special = any_nan | u_cls[0].inf | u_cls[1].inf;
        if (any_nan)
            spec_val = QNAN;
        else if (u_cls[0].inf)
            spec_val = {u_sign[0], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            spec_val = {sb_eff, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end

    // alignment
    logic              al_sgn, al_sub;
    logic [EXP_W-1:0]  al_exp;
    logic [XW-1:0]     al_big, al_small;

    fp_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .sa      (u_sign[0]),
        .ea      (u_exp[0]),
        .ma      (u_sig[0]),
        .sb      (sb_eff),
        .eb      (u_exp[1]),
        .mb      (u_sig[1]),
        .sgn_big (al_sgn),
        .eff_sub (al_sub),
        .exp_big (al_exp),
        .big_x   (al_big),
        .small_x (al_small)
    );

    logic              sgn_q, esub_q;
    logic [EXP_W-1:0]  ebig_q;
    logic [XW-1:0]     bigx_q, smlx_q;

    // significand add/subtract
    logic [XW:0]       mag_c, mag_q;
    logic [EW2-1:0]    exp_q;
    logic              rsgn_q;

    always_comb begin
        mag_c = esub_q ? ({1'b0, bigx_q} - {1'b0, smlx_q})
                       : ({1'b0, bigx_q} + {1'b0, smlx_q});
    end

    // normalization
    logic [XW-1:0]     nm_c, norm_q;
    logic [EW2-1:0]    ne_c, nexp_q;

    fp_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .mag     (mag_q),
        .exp_in  (exp_q),
        .norm    (nm_c),
        .exp_out (ne_c)
    );

    // rounding and packing
    logic [W-1:0]      rnd_res;

    fp_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign (rsgn_q),
        .norm (norm_q),
        .nexp (nexp_q),
        .rm   (rm_q),
        .ftz  (ftz_q),
        .res  (rnd_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_UNPACK;
            ST_UNPACK: state_nx = special ? ST_DONE : ST_ALIGN;
            ST_ALIGN:  state_nx = ST_ADD;
            ST_ADD:    state_nx = ST_NORM;
            ST_NORM:   state_nx = ST_ROUND;
            ST_ROUND:  state_nx = ST_DONE;
            ST_DONE:   if (out_ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_DONE);
        out_sum   = res_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            sub_q  <= 1'b0;
            ftz_q  <= 1'b0;
            rm_q   <= RM_NEAR;
            res_q  <= '0;
            sgn_q  <= 1'b0;
            esub_q <= 1'b0;
            ebig_q <= '0;
            bigx_q <= '0;
            smlx_q <= '0;
            mag_q  <= '0;
            exp_q  <= '0;
            rsgn_q <= 1'b0;
            norm_q <= '0;
            nexp_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (in_valid) begin
                    a_q   <= in_a;
                    b_q   <= in_b;
                    sub_q <= in_sub;
                    ftz_q <= in_ftz;
                    rm_q  <= rmode_e'(in_rmode);
                end
                ST_UNPACK: if (special) res_q <= spec_val;
                ST_ALIGN: begin
                    sgn_q  <= al_sgn;
                    esub_q <= al_sub;
                    ebig_q <= al_exp;
                    bigx_q <= al_big;
                    smlx_q <= al_small;
                end
                ST_ADD: begin
                    mag_q  <= mag_c;
                    exp_q  <= {{(EW2-EXP_W){1'b0}}, ebig_q};
                    // exact zero: sign chosen by the cancellation rule
                    if (mag_c == '0)
                        rsgn_q <= esub_q ? (rm_q == RM_DOWN) : sgn_q;
                    else
                        rsgn_q <= sgn_q;
                end
                ST_NORM: begin
                    norm_q <= nm_c;
                    nexp_q <= ne_c;
                end
                ST_ROUND: res_q <= rnd_res;
                default: ;
            endcase
        end
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R1
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

    // R12
    nan_propagate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (u_cls[0].nan || u_cls[1].nan)) |->
        ((&out_sum[W-2:FRAC_W]) && (|out_sum[FRAC_W-1:0])));

    // R13
    inf_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && u_cls[0].inf && !u_cls[1].inf && !u_cls[1].nan) |->
        (out_sum == {a_q[W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rm_q == RM_ZERO && !u_cls[0].nan && !u_cls[0].inf &&
         !u_cls[1].nan && !u_cls[1].inf) |-> !(&out_sum[W-2:FRAC_W]));

    // R9
    flush_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ftz_q) |->
        !((out_sum[W-2:FRAC_W] == '0) && (|out_sum[FRAC_W-1:0])));

endmodule

// File: tb/fp32_addsub_tb.sv
`timescale 1ns/1ps
module fp32_addsub_tb;

    localparam logic [1:0] NE = 2'b00, TZ = 2'b01, UP = 2'b10, DN = 2'b11;
    localparam logic [31:0] QN = 32'h7FC00000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0, in_b = '0;
    logic        in_sub = 1'b0;
    logic [1:0]  in_rmode = 2'b00;
    logic        in_ftz = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_sum;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    fp32_addsub u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .in_rmode(in_rmode),
        .in_ftz(in_ftz), .out_valid(out_valid), .out_ready(out_ready),
        .out_sum(out_sum)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp_v);
        n_tests++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp_v);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input logic [1:0] rm, input logic ftz);
        @(negedge clk);
        in_a = a; in_b = b; in_sub = sub; in_rmode = rm; in_ftz = ftz;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_out(input string tag);
        int n = 0;
        while (!out_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (!out_valid) begin
            n_tests++;
            n_fail++;
            $display("FAIL %s: got no out_valid expected out_valid=1", tag);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                          input logic [1:0] rm, input logic ftz,
                          input logic [31:0] exp_v, input string tag);
        issue(a, b, sub, rm, ftz);
        wait_out(tag);
        check(tag, out_sum, exp_v);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset in_ready", {31'b0, in_ready}, 32'd1);
        check("R1 reset out_valid", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_hold;
        logic [31:0] snap;
        issue(32'h3FC00000, 32'h40100000, 1'b0, NE, 1'b0);
        check("R1 busy after accept", {31'b0, in_ready}, 32'd0);
        wait_out("R1 hold");
        snap = out_sum;
        repeat (3) @(negedge clk);
        check("R1 out_valid held", {31'b0, out_valid}, 32'd1);
        check("R1 result held", out_sum, snap);
        check("R1 not ready while full", {31'b0, in_ready}, 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R1 idle after take", {31'b0, in_ready}, 32'd1);
    endtask

    task automatic t_basic;
        run_op(32'h3FC00000, 32'h40100000, 1'b0, NE, 1'b0, 32'h40700000, "R2 1.5+2.25");
        run_op(32'h40B80000, 32'hBFC00000, 1'b0, NE, 1'b0, 32'h40880000, "R2 5.75+-1.5");
        run_op(32'h3F800000, 32'h40400000, 1'b1, NE, 1'b0, 32'hC0000000, "R3 1-3");
        run_op(32'hBF800000, 32'hC0400000, 1'b1, NE, 1'b0, 32'h40000000, "R3 -1-(-3)");
    endtask

    task automatic t_ties;
        run_op(32'h3F800000, 32'h33800000, 1'b0, NE, 1'b0, 32'h3F800000, "R4 tie even stays");
        run_op(32'h3F800001, 32'h33800000, 1'b0, NE, 1'b0, 32'h3F800002, "R4 tie odd up");
        run_op(32'h3F800000, 32'h33C00000, 1'b0, NE, 1'b0, 32'h3F800001, "R4 above half");
    endtask

    task automatic t_directed;
        run_op(32'h3F800000, 32'h33800000, 1'b0, UP, 1'b0, 32'h3F800001, "R5 up pos");
        run_op(32'h3F800000, 32'h33800000, 1'b0, DN, 1'b0, 32'h3F800000, "R5 down pos");
        run_op(32'h3F800000, 32'h33C00000, 1'b0, TZ, 1'b0, 32'h3F800000, "R5 zero pos");
        run_op(32'hBF800000, 32'hB3800000, 1'b0, DN, 1'b0, 32'hBF800001, "R5 down neg");
        run_op(32'hBF800000, 32'hB3800000, 1'b0, UP, 1'b0, 32'hBF800000, "R5 up neg");
    endtask

    task automatic t_far;
        run_op(32'h60AD78EC, 32'h3F800000, 1'b0, NE, 1'b0, 32'h60AD78EC, "R6 big+1 nearest");
        run_op(32'h60AD78EC, 32'h3F800000, 1'b0, UP, 1'b0, 32'h60AD78ED, "R6 big+1 up");
        run_op(32'h60AD78EC, 32'h3F800000, 1'b1, TZ, 1'b0, 32'h60AD78EB, "R6 big-1 zero");
        run_op(32'h60AD78EC, 32'h3F800000, 1'b1, NE, 1'b0, 32'h60AD78EC, "R6 big-1 nearest");
    endtask

    task automatic t_carry;
        run_op(32'h3F800000, 32'h3F800000, 1'b0, NE, 1'b0, 32'h40000000, "R7 sum carry");
        run_op(32'h3FFFFFFF, 32'h33800000, 1'b0, NE, 1'b0, 32'h40000000, "R7 round carry");
    endtask

    task automatic t_subnormal;
        run_op(32'h00000001, 32'h00000001, 1'b0, NE, 1'b0, 32'h00000002, "R8 tiny+tiny");
        run_op(32'h00400000, 32'h00400000, 1'b0, NE, 1'b0, 32'h00800000, "R8 sub to normal");
        run_op(32'h00800001, 32'h00800000, 1'b1, NE, 1'b0, 32'h00000001, "R8 normal to sub");
        run_op(32'h00000003, 32'h00000001, 1'b1, NE, 1'b0, 32'h00000002, "R8 sub-sub");
        run_op(32'h3F800000, 32'h00000001, 1'b0, UP, 1'b0, 32'h3F800001, "R8 sub sticky up");
    endtask

    task automatic t_ftz;
        run_op(32'h00400000, 32'h00400000, 1'b0, NE, 1'b1, 32'h00000000, "R9 inputs flushed");
        run_op(32'h3F800000, 32'h00000001, 1'b0, UP, 1'b1, 32'h3F800000, "R9 no sticky from flushed");
        run_op(32'h00800001, 32'h00800000, 1'b1, NE, 1'b1, 32'h00000000, "R9 result flushed pos");
        run_op(32'h80800001, 32'h80800000, 1'b1, NE, 1'b1, 32'h80000000, "R9 result flushed neg");
    endtask

    task automatic t_cancel;
        run_op(32'h3FC00000, 32'h3FC00000, 1'b1, NE, 1'b0, 32'h00000000, "R10 x-x nearest");
        run_op(32'h3FC00000, 32'h3FC00000, 1'b1, UP, 1'b0, 32'h00000000, "R10 x-x up");
        run_op(32'h3FC00000, 32'h3FC00000, 1'b1, DN, 1'b0, 32'h80000000, "R10 x-x down");
        run_op(32'h80000000, 32'h80000000, 1'b0, NE, 1'b0, 32'h80000000, "R10 -0+-0");
        run_op(32'h00000000, 32'h80000000, 1'b0, NE, 1'b0, 32'h00000000, "R10 +0+-0");
    endtask

    task automatic t_overflow;
        run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, NE, 1'b0, 32'h7F800000, "R11 nearest inf");
        run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, TZ, 1'b0, 32'h7F7FFFFF, "R11 zero max");
        run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, DN, 1'b0, 32'h7F7FFFFF, "R11 down pos max");
        run_op(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, UP, 1'b0, 32'hFF7FFFFF, "R11 up neg max");
        run_op(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, DN, 1'b0, 32'hFF800000, "R11 down neg inf");
        run_op(32'h7F7FFFFF, 32'h73000000, 1'b0, NE, 1'b0, 32'h7F800000, "R11 rounding overflow");
    endtask

    task automatic t_nan;
        run_op(32'h7FC00001, 32'h3F800000, 1'b0, NE, 1'b0, QN, "R12 nan a");
        run_op(32'h3F800000, 32'hFF800001, 1'b0, NE, 1'b0, QN, "R12 nan b");
        run_op(32'h7F800000, 32'h7F800000, 1'b1, NE, 1'b0, QN, "R12 inf-inf");
        run_op(32'h7F800000, 32'hFF800000, 1'b0, NE, 1'b0, QN, "R12 inf+-inf");
    endtask

    task automatic t_inf;
        run_op(32'h7F800000, 32'h3F800000, 1'b0, NE, 1'b0, 32'h7F800000, "R13 inf+1");
        run_op(32'h3F800000, 32'h7F800000, 1'b1, NE, 1'b0, 32'hFF800000, "R13 1-inf");
        run_op(32'hFF800000, 32'hFF800000, 1'b0, NE, 1'b0, 32'hFF800000, "R13 -inf+-inf");
    endtask

    initial begin
        #4000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_basic();
        t_ties();
        t_directed();
        t_far();
        t_carry();
        t_subnormal();
        t_ftz();
        t_cancel();
        t_overflow();
        t_nan();
        t_inf();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule